// File: doc/BRIEF.md
# Secondary Core Power-Up Sequencer

This block brings one secondary processor core from its cold, clamped state to a running state. A single start pulse arms it. It first waits for the shared cache power domain to report ready. It then steps through a fixed list of actions on the core's power controls. Between actions it inserts waits of whole microseconds, counted in clock cycles.

The controls it drives are:
- a two-stage head-switch enable, with a skew value for hardware-staggered switching;
- the core reset;
- the core-memory clamp and gate;
- two core clamp stages;
- a power-up-done flag.

Two profiles are provided, and the one used is picked at start:
- Profile A stages the head switches in two steps and drops the two core clamps separately.
- Profile B asserts reset first, relies on a programmed head-switch skew, and uses longer waits.

If the cache domain never reports ready, the block raises an error and leaves every core control at its cold value. All pins are plain level controls. There is no data stream and therefore no valid/ready handshake.

Top module: `core_pwrup_seq`

## Requirements
- R1: After reset the outputs hold these cold values: hs_en_o=2'b00, hs_skew_o=0, core_rst_o=1, mem_clamp_o=1, mem_gate_o=0, core_clamp_o=2'b11, pwr_up_o=0, done_o=0 and error_o=0.
- R2: A start_i sampled high while idle captures profile_i (0 = profile A, 1 = profile B). Later changes of profile_i have no effect on that run.
- R3: No core output changes before cache_ready_i is sampled high. A ready seen at any of the first CACHE_TMO rising edges after the start edge launches the first action at that same edge.
- R4: If cache_ready_i is not seen within those CACHE_TMO edges, error_o is set and every core output keeps its cold value. The block then returns to idle. A new start clears error_o.
- R5: Profile A applies these actions in order, each as a registered change:
  1. hs_en_o=01, then wait 1 us.
  2. hs_en_o=11, then wait 1 us.
  3. mem_clamp_o=0.
  4. mem_gate_o=1, then wait 1 us.
  5. core_clamp_o[0]=0.
  6. core_clamp_o[1]=0, then wait 1 us.
  7. core_rst_o=0.
  8. pwr_up_o=1.

  Each action follows the previous one by 1 + W cycles, where W is the previous action's wait in cycles (1 us = US_CYCLES cycles).
- R6: Profile B applies these actions in order:
  1. core_rst_o=1.
  2. hs_en_o=11 together with hs_skew_o=SKEW_CYC, then wait 2 us.
  3. mem_clamp_o=0.
  4. mem_gate_o=1, then wait 2 us.
  5. core_clamp_o=00, then wait 2 us.
  6. core_rst_o=0.
  7. pwr_up_o=1.

  Spacing is the same as in R5.
- R7: Core reset is released exactly one cycle before pwr_up_o rises. done_o rises on the same edge as pwr_up_o. After that, done_o and all core outputs stay fixed and start_i is ignored until reset.
- R8: start_i pulses while the block is waiting for the cache or running the sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| profile_i | input | 1 | Profile select, 0 = A, 1 = B |
| cache_ready_i | input | 1 | Shared cache domain powered and ready |
| hs_en_o | output | 2 | Head-switch enable, bit 0 first stage, bit 1 remaining switches |
| hs_skew_o | output | SKEW_W | Programmed head-switch skew in reference cycles |
| core_rst_o | output | 1 | Core reset, 1 = asserted |
| mem_clamp_o | output | 1 | Core-memory clamp, 1 = clamped |
| mem_gate_o | output | 1 | Core-memory array gate, 1 = closed (powered) |
| core_clamp_o | output | 2 | Core clamp stages, 1 = clamped |
| pwr_up_o | output | 1 | Power-up-done flag to the core |
| done_o | output | 1 | Sequence complete |
| error_o | output | 1 | Cache domain did not become ready in time |

## Verification
Both profiles are run with the cache ready delayed and with it already high. Comparing every output on every cycle separates the two action lists, their wait lengths and their release order.

A run where profile_i flips right after start shows whether the profile is captured or followed live. Start pulses injected mid-run show whether a busy sequencer can be restarted.

Cache-ready arriving exactly on the last allowed edge, and one edge too late, pins down the timeout boundary. The timed-out run, followed by a successful retry, shows that an error leaves the core untouched and is cleared by the next start.

// File: rtl/core_pwr_pkg.sv
package core_pwr_pkg;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_HS_FEW,
    ACT_HS_ALL,
    ACT_HS_SKEW,
    ACT_RST_ON,
    ACT_MCLAMP_OFF,
    ACT_MGATE_ON,
    ACT_CLAMP0_OFF,
    ACT_CLAMP1_OFF,
    ACT_CLAMP_ALL_OFF,
    ACT_RST_OFF,
    ACT_PWRUP
  } act_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CACHE,
    PH_RUN,
    PH_UP
  } phase_e;

  typedef struct packed {
    logic [1:0] hs_en;
    logic       skew_on;
    logic       core_rst;
    logic       mem_clamp;
    logic       mem_gate;
    logic [1:0] core_clamp;
    logic       pwr_up;
  } core_ctl_t;

  typedef struct packed {
    act_e       act;
    logic [1:0] wait_us;
    logic       last;
  } step_t;

  localparam int STEP_W = 3;

  localparam core_ctl_t CTL_COLD = '{
    hs_en:      2'b00,
    skew_on:    1'b0,
    core_rst:   1'b1,
    mem_clamp:  1'b1,
    mem_gate:   1'b0,
    core_clamp: 2'b11,
    pwr_up:     1'b0
  };

  // Step table for both profiles; index counts actions from zero.
  function automatic step_t step_lookup(input logic prof_b, input logic [STEP_W-1:0] idx);
    step_t s;
    s = '{act: ACT_NONE, wait_us: 2'd0, last: 1'b1};
    if (!prof_b) begin
      case (idx)
        3'd0: s = '{act: ACT_HS_FEW,     wait_us: 2'd1, last: 1'b0};
        3'd1: s = '{act: ACT_HS_ALL,     wait_us: 2'd1, last: 1'b0};
        3'd2: s = '{act: ACT_MCLAMP_OFF, wait_us: 2'd0, last: 1'b0};
        3'd3: s = '{act: ACT_MGATE_ON,   wait_us: 2'd1, last: 1'b0};
        3'd4: s = '{act: ACT_CLAMP0_OFF, wait_us: 2'd0, last: 1'b0};
        3'd5: s = '{act: ACT_CLAMP1_OFF, wait_us: 2'd1, last: 1'b0};
        3'd6: s = '{act: ACT_RST_OFF,    wait_us: 2'd0, last: 1'b0};
        default: s = '{act: ACT_PWRUP,   wait_us: 2'd0, last: 1'b1};
      endcase
    end else begin
      case (idx)
        3'd0: s = '{act: ACT_RST_ON,        wait_us: 2'd0, last: 1'b0};
        3'd1: s = '{act: ACT_HS_SKEW,       wait_us: 2'd2, last: 1'b0};
        3'd2: s = '{act: ACT_MCLAMP_OFF,    wait_us: 2'd0, last: 1'b0};
        3'd3: s = '{act: ACT_MGATE_ON,      wait_us: 2'd2, last: 1'b0};
        3'd4: s = '{act: ACT_CLAMP_ALL_OFF, wait_us: 2'd2, last: 1'b0};
        3'd5: s = '{act: ACT_RST_OFF,       wait_us: 2'd0, last: 1'b0};
        3'd6: s = '{act: ACT_PWRUP,         wait_us: 2'd0, last: 1'b1};
        default: s = '{act: ACT_NONE,       wait_us: 2'd0, last: 1'b1};
      endcase
    end
    return s;
  endfunction

  function automatic core_ctl_t apply_act(input core_ctl_t c, input act_e a);
    core_ctl_t n;
    n = c;
    case (a)
      ACT_HS_FEW:        n.hs_en = 2'b01;
      ACT_HS_ALL:        n.hs_en = 2'b11;
      ACT_HS_SKEW: begin
        n.hs_en   = 2'b11;
        n.skew_on = 1'b1;
      end
      ACT_RST_ON:        n.core_rst = 1'b1;
      ACT_MCLAMP_OFF:    n.mem_clamp = 1'b0;
      ACT_MGATE_ON:      n.mem_gate = 1'b1;
      ACT_CLAMP0_OFF:    n.core_clamp[0] = 1'b0;
      ACT_CLAMP1_OFF:    n.core_clamp[1] = 1'b0;
      ACT_CLAMP_ALL_OFF: n.core_clamp = 2'b00;
      ACT_RST_OFF:       n.core_rst = 1'b0;
      ACT_PWRUP:         n.pwr_up = 1'b1;
      default:           n = c;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/core_pwr_timer.sv
module core_pwr_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/core_pwr_step_rom.sv
module core_pwr_step_rom
  import core_pwr_pkg::*;
#(
  parameter int US_CYCLES = 50,
  parameter int TW        = 8
) (
  input  logic              prof_b_i,
  input  logic [STEP_W-1:0] idx_i,
  output act_e              act_o,
  output logic              last_o,
  output logic [TW-1:0]     wait_cyc_o
);

  step_t cur;

  always_comb begin
    cur        = step_lookup(prof_b_i, idx_i);
    act_o      = cur.act;
    last_o     = cur.last;
    wait_cyc_o = TW'(int'(cur.wait_us) * US_CYCLES);
  end

endmodule

// File: rtl/core_pwr_ctl_reg.sv
module core_pwr_ctl_reg
  import core_pwr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      apply_i,
  input  act_e      act_i,
  output core_ctl_t ctl_o
);

  core_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= CTL_COLD;
    end else if (apply_i) begin
      ctl_q <= apply_act(ctl_q, act_i);
    end
  end

  assign ctl_o = ctl_q;

endmodule

// File: rtl/core_pwr_fsm.sv
module core_pwr_fsm
  import core_pwr_pkg::*;
#(
  parameter int CACHE_TMO = 2000,
  parameter int TW        = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              profile_i,
  input  logic              cache_ready_i,
  input  logic              timer_zero_i,
  input  logic              step_last_i,
  input  logic [TW-1:0]     step_wait_i,
  output logic              prof_b_o,
  output logic [STEP_W-1:0] step_idx_o,
  output logic              apply_o,
  output logic              timer_load_o,
  output logic [TW-1:0]     timer_val_o,
  output logic              done_o,
  output logic              error_o
);

  localparam logic [TW-1:0] TMO_LOAD = TW'(CACHE_TMO - 1);

  phase_e            phase_q, phase_d;
  logic              prof_q, prof_d;
  logic [STEP_W-1:0] idx_q, idx_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  always_comb begin
    phase_d      = phase_q;
    prof_d       = prof_q;
    idx_d        = idx_q;
    done_d       = done_q;
    err_d        = err_q;
    apply_o      = 1'b0;
    timer_load_o = 1'b0;
    timer_val_o  = '0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d      = PH_CACHE;
          prof_d       = profile_i;
          err_d        = 1'b0;
          timer_load_o = 1'b1;
          timer_val_o  = TMO_LOAD;
        end
      end
      PH_CACHE: begin
        if (cache_ready_i) begin
          apply_o      = 1'b1;
          timer_load_o = 1'b1;
          timer_val_o  = step_wait_i;
          idx_d        = STEP_W'(1);
          phase_d      = PH_RUN;
        end else if (timer_zero_i) begin
          err_d   = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      PH_RUN: begin
        if (timer_zero_i) begin
          apply_o      = 1'b1;
          timer_load_o = 1'b1;
          timer_val_o  = step_wait_i;
          idx_d        = idx_q + 1'b1;
          if (step_last_i) begin
            done_d  = 1'b1;
            phase_d = PH_UP;
          end
        end
      end
      default: begin
        phase_d = PH_UP;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      prof_q  <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      prof_q  <= prof_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // While waiting for the cache, the first table entry is presented.
  assign step_idx_o = (phase_q == PH_CACHE) ? '0 : idx_q;
  assign prof_b_o   = prof_q;
  assign done_o     = done_q;
  assign error_o    = err_q;

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
  import core_pwr_pkg::*;
#(
  parameter int US_CYCLES = 50,
  parameter int CACHE_TMO = 2000,
  parameter int SKEW_CYC  = 16,
  localparam int SKEW_W   = $clog2(SKEW_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              profile_i,
  input  logic              cache_ready_i,
  output logic [1:0]        hs_en_o,
  output logic [SKEW_W-1:0] hs_skew_o,
  output logic              core_rst_o,
  output logic              mem_clamp_o,
  output logic              mem_gate_o,
  output logic [1:0]        core_clamp_o,
  output logic              pwr_up_o,
  output logic              done_o,
  output logic              error_o
);

  localparam int MAX_WAIT = 2 * US_CYCLES;
  localparam int MAX_CNT  = (CACHE_TMO > MAX_WAIT) ? CACHE_TMO : MAX_WAIT;
  localparam int TW       = $clog2(MAX_CNT + 1);

  logic              prof_b;
  logic [STEP_W-1:0] step_idx;
  act_e              step_act;
  logic              step_last;
  logic [TW-1:0]     step_wait;
  logic              apply;
  logic              timer_load;
  logic [TW-1:0]     timer_val;
  logic              timer_zero;
  core_ctl_t         ctl;

  core_pwr_fsm #(
    .CACHE_TMO (CACHE_TMO),
    .TW        (TW)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .profile_i     (profile_i),
    .cache_ready_i (cache_ready_i),
    .timer_zero_i  (timer_zero),
    .step_last_i   (step_last),
    .step_wait_i   (step_wait),
    .prof_b_o      (prof_b),
    .step_idx_o    (step_idx),
    .apply_o       (apply),
    .timer_load_o  (timer_load),
    .timer_val_o   (timer_val),
    .done_o        (done_o),
    .error_o       (error_o)
  );

  core_pwr_step_rom #(
    .US_CYCLES (US_CYCLES),
    .TW        (TW)
  ) u_rom (
    .prof_b_i   (prof_b),
    .idx_i      (step_idx),
    .act_o      (step_act),
    .last_o     (step_last),
    .wait_cyc_o (step_wait)
  );

  core_pwr_timer #(
    .TW (TW)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (timer_load),
    .load_val_i (timer_val),
    .zero_o     (timer_zero)
  );

  core_pwr_ctl_reg u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .apply_i (apply),
    .act_i   (step_act),
    .ctl_o   (ctl)
  );

  assign hs_en_o      = ctl.hs_en;
  assign hs_skew_o    = ctl.skew_on ? SKEW_W'(SKEW_CYC) : '0;
  assign core_rst_o   = ctl.core_rst;
  assign mem_clamp_o  = ctl.mem_clamp;
  assign mem_gate_o   = ctl.mem_gate;
  assign core_clamp_o = ctl.core_clamp;
  assign pwr_up_o     = ctl.pwr_up;

endmodule

// File: rtl/core_pwrup_seq_chk.sv
module core_pwrup_seq_chk #(
  parameter int SKEW_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cache_ready_i,
  input logic [1:0]        hs_en_o,
  input logic [SKEW_W-1:0] hs_skew_o,
  input logic              core_rst_o,
  input logic              mem_clamp_o,
  input logic              mem_gate_o,
  input logic [1:0]        core_clamp_o,
  input logic              pwr_up_o,
  input logic              done_o,
  input logic              error_o
);

  logic rdy_seen_q;
  logic cold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdy_seen_q <= 1'b0;
    else if (cache_ready_i) rdy_seen_q <= 1'b1;
  end

  assign cold = (hs_en_o == 2'b00) && (hs_skew_o == '0) && core_rst_o && mem_clamp_o &&
                !mem_gate_o && (core_clamp_o == 2'b11) && !pwr_up_o;

  // R3: core controls untouched until the cache domain has been seen ready
  p_untouched_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_seen_q |-> cold);

  // R4: an error leaves the core in its cold state
  p_err_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> cold);

  // R5: second head-switch stage never on without the first
  p_hs_stage_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_en_o[1] |-> hs_en_o[0]);

  // R5: core reset is released only once both clamp stages are open
  p_rst_after_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_rst_o |-> (core_clamp_o == 2'b00));

  // R6: memory gate closes only after the memory clamp has been released
  p_gate_after_mclamp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_gate_o |-> !mem_clamp_o);

  // R7: power-up flag rises exactly one cycle after reset release
  p_flag_after_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_up_o) |-> (!$past(core_rst_o) && $past(core_rst_o, 2)));

  // R7: done implies the core is fully up
  p_done_final_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pwr_up_o && !core_rst_o && !mem_clamp_o && mem_gate_o &&
                (core_clamp_o == 2'b00) && (hs_en_o == 2'b11)));

  // R7: done is sticky
  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

endmodule

bind core_pwrup_seq core_pwrup_seq_chk #(.SKEW_W(SKEW_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cache_ready_i (cache_ready_i),
  .hs_en_o       (hs_en_o),
  .hs_skew_o     (hs_skew_o),
  .core_rst_o    (core_rst_o),
  .mem_clamp_o   (mem_clamp_o),
  .mem_gate_o    (mem_gate_o),
  .core_clamp_o  (core_clamp_o),
  .pwr_up_o      (pwr_up_o),
  .done_o        (done_o),
  .error_o       (error_o)
);

// File: tb/tb_core_pwrup_seq.sv
`timescale 1ns/1ps
module tb_core_pwrup_seq;

  localparam int US  = 5;
  localparam int TMO = 20;
  localparam int SKW = 16;
  localparam int SW  = $clog2(SKW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          prof = 1'b0;
  logic          rdy = 1'b0;
  logic [1:0]    hs_en;
  logic [SW-1:0] hs_skew;
  logic          core_rst, mem_clamp, mem_gate, pwr_up, done, err;
  logic [1:0]    core_clamp;

  always #10 clk = ~clk;

  core_pwrup_seq #(.US_CYCLES(US), .CACHE_TMO(TMO), .SKEW_CYC(SKW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .profile_i(prof), .cache_ready_i(rdy),
    .hs_en_o(hs_en), .hs_skew_o(hs_skew), .core_rst_o(core_rst), .mem_clamp_o(mem_clamp),
    .mem_gate_o(mem_gate), .core_clamp_o(core_clamp), .pwr_up_o(pwr_up),
    .done_o(done), .error_o(err)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int    m_ph;          // 0 idle, 1 cache wait, 2 running, 3 up
  int    m_prof, m_tcnt, m_gap;
  int    m_acts[$];
  int    m_waits[$];
  string m_tag = "R1";
  int    e_hs, e_skew, e_rst, e_mcl, e_mg, e_cl, e_pup, e_done, e_err;

  task automatic m_cold();
    e_hs = 0; e_skew = 0; e_rst = 1; e_mcl = 1; e_mg = 0; e_cl = 3; e_pup = 0;
  endtask

  // Action codes: 1 few hs, 2 all hs, 3 all hs + skew, 4 reset on, 5 mem clamp off,
  // 6 mem gate on, 7 clamp0 off, 8 clamp1 off, 9 both clamps off, 10 reset off, 11 flag
  task automatic m_do(input int a);
    case (a)
      1: e_hs = 1;
      2: e_hs = 3;
      3: begin e_hs = 3; e_skew = SKW; end
      4: e_rst = 1;
      5: e_mcl = 0;
      6: e_mg = 1;
      7: e_cl = e_cl & 2;
      8: e_cl = e_cl & 1;
      9: e_cl = 0;
      10: e_rst = 0;
      11: e_pup = 1;
      default: ;
    endcase
  endtask

  task automatic m_fill(input int p);
    m_acts.delete(); m_waits.delete();
    if (p == 0) begin
      m_acts = '{1, 2, 5, 6, 7, 8, 10, 11};
      m_waits = '{US, US, 0, US, 0, US, 0, 0};
    end else begin
      m_acts = '{4, 3, 5, 6, 9, 10, 11};
      m_waits = '{0, 2*US, 0, 2*US, 2*US, 0, 0};
    end
  endtask

  task automatic m_pop();
    int a, w;
    a = m_acts.pop_front();
    w = m_waits.pop_front();
    m_do(a);
    m_gap = w;
    if (m_acts.size() == 0) begin
      m_ph = 3; e_done = 1; m_tag = "R7";
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cold(); e_done = 0; e_err = 0; m_ph = 0; m_tag = "R1";
    end else begin
      case (m_ph)
        0: if (start) begin
             m_prof = prof; m_ph = 1; m_tcnt = 0; e_err = 0; m_tag = "R3";
           end
        1: begin
             m_tcnt++;
             if (rdy) begin
               m_fill(m_prof); m_ph = 2; m_tag = (m_prof == 1) ? "R6" : "R5"; m_pop();
             end else if (m_tcnt == TMO) begin
               e_err = 1; m_ph = 0; m_tag = "R4";
             end
           end
        2: if (m_gap > 0) m_gap--; else m_pop();
        default: ;
      endcase
    end
  end

  // Full output comparison every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({m_tag, " hs_en"}, hs_en, e_hs);
      chk({m_tag, " hs_skew"}, hs_skew, e_skew);
      chk({m_tag, " core_rst"}, core_rst, e_rst);
      chk({m_tag, " mem_clamp"}, mem_clamp, e_mcl);
      chk({m_tag, " mem_gate"}, mem_gate, e_mg);
      chk({m_tag, " core_clamp"}, core_clamp, e_cl);
      chk({m_tag, " pwr_up"}, pwr_up, e_pup);
      chk({m_tag, " done"}, done, e_done);
      chk({m_tag, " error"}, err, e_err);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; start = 0; rdy = 0;
    cyc(2); rst_n = 1;
  endtask

  task automatic pulse_start(input logic p);
    prof = p; start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    chk({req, " done reached"}, done, 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    cyc(3); rst_n = 1; @(negedge clk);
    // R1: cold values after reset
    chk("R1 hs_en", hs_en, 0); chk("R1 core_rst", core_rst, 1);
    chk("R1 mem_clamp", mem_clamp, 1); chk("R1 core_clamp", core_clamp, 3);
    chk("R1 done", done, 0); chk("R1 error", err, 0);

    // Profile A, cache ready late, profile flips after start (R2)
    pulse_start(1'b0); prof = 1'b1;
    cyc(5);
    chk("R3 untouched before ready", hs_en, 0);
    rdy = 1;
    begin
      int n = 0;
      while (hs_en == 0 && n < 100) begin @(negedge clk); n++; end
    end
    chk("R2 captured profile A first stage", hs_en, 1);
    wait_done("R5");
    chk("R5 two clamps open", core_clamp, 0);
    pulse_start(1'b1); cyc(5);
    chk("R7 done sticky after start", done, 1);
    chk("R7 skew stays zero in A", hs_skew, 0);

    // Profile B with ready already high and busy start pulses (R8)
    do_reset(); rdy = 1;
    pulse_start(1'b1);
    cyc(3); pulse_start(1'b0);
    cyc(8); pulse_start(1'b0);
    wait_done("R6");
    chk("R6 skew programmed", hs_skew, SKW);
    chk("R8 busy start ignored, B completes", pwr_up, 1);

    // Timeout (R4), then successful retry clears error
    do_reset(); rdy = 0;
    pulse_start(1'b0); cyc(TMO + 3);
    chk("R4 error raised", err, 1);
    chk("R4 core untouched", core_rst, 1);
    chk("R4 gate untouched", mem_gate, 0);
    pulse_start(1'b1); cyc(2);
    chk("R4 error cleared by start", err, 0);
    rdy = 1; wait_done("R4 retry");

    // Ready on the last allowed edge (R3 boundary accept)
    do_reset(); rdy = 0;
    pulse_start(1'b0); cyc(TMO - 1); rdy = 1; cyc(2);
    chk("R3 last-edge ready accepted", err, 0);
    wait_done("R3 boundary");

    // Ready one edge too late (R3/R4 boundary reject)
    do_reset(); rdy = 0;
    pulse_start(1'b1); cyc(TMO); rdy = 1; cyc(2);
    chk("R4 late ready rejected", err, 1);
    chk("R3 late ready leaves hs off", hs_en, 0);
    cyc(3);
    summary();
  end

endmodule